// File: doc/BRIEF.md
# Buck Converter Real-Time Solver

This block is a fixed-step, real-time model of a synchronous buck converter for hardware-in-the-loop rigs. On each start pulse it samples the gate commands of the high-side and low-side switches. It then advances the two state variables, inductor current and capacitor voltage, by one integration step. The step is a four-stage Runge–Kutta update carried out in signed fixed-point arithmetic. The physical parameters reach the block as precomputed coefficients on input ports: step size over inductance, step size over capacitance, step size over the product of load resistance and capacitance, and the source voltage.

When both switches are open (deadtime), the source delivers no energy. The inductor current can then only fall toward zero, and the freewheeling path it takes depends on its sign. If the newly computed current crosses or touches zero during a deadtime, the block forces it to exactly zero. It keeps the current there for as long as the deadtime lasts, so that the capacitor integration that follows sees the physically correct current.

Top module: `buck_rk4_solver`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first cycle after it, both states read zero and `done` and `busy` are low.
- R2: A high `start` seen on a clock edge while `busy` is low begins a step. `busy` is high from the next cycle. `done` is high for exactly one cycle, raised by the fifth edge after the accepting edge. `il_out` and `vc_out` change only on the edge that raises `done`.
- R3: `start` is ignored while `busy` is high. A step always ends after five edges, and no new step follows unless `start` is high again once `busy` is low.
- R4: The gate inputs (1 = switch closed), the coefficients and the source voltage are sampled on the accepting edge. Changes to them during a step have no effect on its result.
- R5: All values are two's complement with FRAC fraction bits. A step with state (i0, v0) computes f(i, v) = (trunc(kl·(u − v)), trunc(kc·i) − trunc(krc·v)), where trunc(a·b) is the product shifted arithmetically right by FRAC. The stages are k1 = f(x0), k2 = f(x0 + k1>>>1), k3 = f(x0 + k2>>>1) and k4 = f(x0 + k3). The new state is x0 + trunc((k1 + 2k2 + 2k3 + k4) · S), where S = (2^FRAC + 3)/6 in integer division.
- R6: The drive voltage u equals the source voltage when the high-side gate is 1, whatever the low-side gate is. It is 0 when only the low-side gate is 1. In a deadtime it is the source voltage if the step's starting current is negative, and 0 otherwise.
- R7: Every stage input, every derivative and every new state is saturated to the W-bit signed range instead of wrapping.
- R8: In a deadtime step, if the new current is zero or its sign bit differs from that of the starting current, the stored current becomes exactly zero.
- R9: After such a clamp, each following deadtime step keeps the current at zero and integrates the capacitor with zero current (dv = −trunc(krc·v)). The hold ends with the first step that samples a closed switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one integration step |
| gate_hi | input | 1 | High-side switch command, 1 = closed |
| gate_lo | input | 1 | Low-side switch command, 1 = closed |
| k_dt_l | input | W | Step size over inductance, Q format |
| k_dt_c | input | W | Step size over capacitance, Q format |
| k_dt_rc | input | W | Step size over R·C, Q format |
| k_vsrc | input | W | Source voltage, Q format |
| il_out | output | W | Inductor current state |
| vc_out | output | W | Capacitor voltage state |
| done | output | 1 | One-cycle strobe when a step commits |
| busy | output | 1 | Step in progress |

## Verification
The bench builds the block with its defaults, W = 24 and FRAC = 16, so the range is about ±128 with a resolution of 1/65536. This is narrow enough that a source of 100 with a unit inductor coefficient drives both states into saturation within a few steps. With a unit inductor coefficient and a half capacitor coefficient, the tank swings fast enough that a short charge phase followed by deadtime clamps the current within two steps. A low-side phase after that drives the current negative, which reaches the negative-current deadtime branch. The same widths keep every intermediate product within 64 bits, so the bench's integer model matches the block bit for bit.

// File: rtl/buck_pkg.sv
package buck_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STAGE = 2'd1,
    ST_FIN   = 2'd2
  } step_state_e;

  // Clamp a wide signed value into a w-bit signed range.
  function automatic logic signed [63:0] sat_w(input logic signed [63:0] x,
                                               input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  // Fixed-point product with truncation toward minus infinity.
  function automatic logic signed [63:0] qmul(input logic signed [63:0] a,
                                              input logic signed [63:0] b,
                                              input int unsigned f);
    logic signed [63:0] p;
    p = a * b;
    return p >>> f;
  endfunction

endpackage

// File: rtl/buck_deriv.sv
module buck_deriv
  import buck_pkg::*;
#(
  parameter int W    = 24,
  parameter int FRAC = 16
) (
  input  logic signed [W-1:0] i_in,
  input  logic signed [W-1:0] v_in,
  input  logic signed [W-1:0] u_in,
  input  logic signed [W-1:0] kl,
  input  logic signed [W-1:0] kc,
  input  logic signed [W-1:0] krc,
  input  logic                hold,
  output logic signed [W-1:0] di_out,
  output logic signed [W-1:0] dv_out
);

  logic signed [63:0] i_eff;
  logic signed [63:0] di_w;
  logic signed [63:0] dv_w;

  always_comb begin
    i_eff = hold ? 64'sd0 : 64'(i_in);
    di_w  = hold ? 64'sd0
                 : sat_w(qmul(64'(kl), 64'(u_in) - 64'(v_in), FRAC), W);
    dv_w  = sat_w(qmul(64'(kc), i_eff, FRAC) - qmul(64'(krc), 64'(v_in), FRAC), W);
    di_out = di_w[W-1:0];
    dv_out = dv_w[W-1:0];
  end

endmodule

// File: rtl/buck_commit.sv
module buck_commit
  import buck_pkg::*;
#(
  parameter int W    = 24,
  parameter int FRAC = 16,
  parameter int AW   = W + 3
) (
  input  logic signed [W-1:0]  i0,
  input  logic signed [W-1:0]  v0,
  input  logic signed [AW-1:0] acc_i,
  input  logic signed [AW-1:0] acc_v,
  input  logic                 dead,
  input  logic                 hold_in,
  output logic signed [W-1:0]  i_next,
  output logic signed [W-1:0]  v_next,
  output logic                 hold_next
);

  localparam logic signed [63:0] SIXTH = ((64'sd1 <<< FRAC) + 64'sd3) / 64'sd6;

  logic signed [63:0] ni_w;
  logic signed [63:0] nv_w;
  logic signed [W-1:0] ni;
  logic                clamp;

  always_comb begin
    ni_w  = sat_w(64'(i0) + qmul(64'(acc_i), SIXTH, FRAC), W);
    nv_w  = sat_w(64'(v0) + qmul(64'(acc_v), SIXTH, FRAC), W);
    ni    = ni_w[W-1:0];
    clamp = dead & (hold_in | (ni == '0) | (ni[W-1] != i0[W-1]));
    i_next    = clamp ? '0 : ni;
    v_next    = nv_w[W-1:0];
    hold_next = clamp;
  end

endmodule

// File: rtl/buck_rk4_solver.sv
module buck_rk4_solver
  import buck_pkg::*;
#(
  parameter int W    = 24,
  parameter int FRAC = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                gate_hi,
  input  logic                gate_lo,
  input  logic signed [W-1:0] k_dt_l,
  input  logic signed [W-1:0] k_dt_c,
  input  logic signed [W-1:0] k_dt_rc,
  input  logic signed [W-1:0] k_vsrc,
  output logic signed [W-1:0] il_out,
  output logic signed [W-1:0] vc_out,
  output logic                done,
  output logic                busy
);

  localparam int AW = W + 3;

  step_state_e         state_q;
  logic [1:0]          cnt_q;
  logic signed [W-1:0] kl_q, kc_q, krc_q, u_q;
  logic                dead_q;
  logic signed [W-1:0] il_q, vc_q;
  logic                hold_q;
  logic signed [W-1:0] kpi_q, kpv_q;
  logic signed [AW-1:0] acc_i_q, acc_v_q;
  logic                done_q;

  logic signed [63:0]  si_w, sv_w;
  logic signed [W-1:0] si, sv, di, dv;
  logic signed [AW-1:0] di_x, dv_x, wi, wv;
  logic signed [W-1:0] il_nx, vc_nx;
  logic                hold_nx;
  logic                hold_eff;

  // Stage operand selection: x0, x0 + k/2 (twice), x0 + k.
  always_comb begin
    case (cnt_q)
      2'd0: begin
        si_w = 64'(il_q);
        sv_w = 64'(vc_q);
      end
      2'd3: begin
        si_w = sat_w(64'(il_q) + 64'(kpi_q), W);
        sv_w = sat_w(64'(vc_q) + 64'(kpv_q), W);
      end
      default: begin
        si_w = sat_w(64'(il_q) + 64'(kpi_q >>> 1), W);
        sv_w = sat_w(64'(vc_q) + 64'(kpv_q >>> 1), W);
      end
    endcase
    si = si_w[W-1:0];
    sv = sv_w[W-1:0];
  end

  assign hold_eff = dead_q & hold_q;

  buck_deriv #(.W(W), .FRAC(FRAC)) u_deriv (
    .i_in   (si),
    .v_in   (sv),
    .u_in   (u_q),
    .kl     (kl_q),
    .kc     (kc_q),
    .krc    (krc_q),
    .hold   (hold_eff),
    .di_out (di),
    .dv_out (dv)
  );

  // RK4 weights 1, 2, 2, 1.
  always_comb begin
    di_x = AW'(di);
    dv_x = AW'(dv);
    if (cnt_q == 2'd0 || cnt_q == 2'd3) begin
      wi = di_x;
      wv = dv_x;
    end else begin
      wi = di_x <<< 1;
      wv = dv_x <<< 1;
    end
  end

  buck_commit #(.W(W), .FRAC(FRAC), .AW(AW)) u_commit (
    .i0        (il_q),
    .v0        (vc_q),
    .acc_i     (acc_i_q),
    .acc_v     (acc_v_q),
    .dead      (dead_q),
    .hold_in   (hold_q),
    .i_next    (il_nx),
    .v_next    (vc_nx),
    .hold_next (hold_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      kl_q    <= '0;
      kc_q    <= '0;
      krc_q   <= '0;
      u_q     <= '0;
      dead_q  <= 1'b0;
      il_q    <= '0;
      vc_q    <= '0;
      hold_q  <= 1'b0;
      kpi_q   <= '0;
      kpv_q   <= '0;
      acc_i_q <= '0;
      acc_v_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            kl_q    <= k_dt_l;
            kc_q    <= k_dt_c;
            krc_q   <= k_dt_rc;
            u_q     <= (gate_hi | (~gate_lo & il_q[W-1])) ? k_vsrc : '0;
            dead_q  <= ~gate_hi & ~gate_lo;
            acc_i_q <= '0;
            acc_v_q <= '0;
            cnt_q   <= '0;
            state_q <= ST_STAGE;
          end
        end
        ST_STAGE: begin
          kpi_q   <= di;
          kpv_q   <= dv;
          acc_i_q <= acc_i_q + wi;
          acc_v_q <= acc_v_q + wv;
          cnt_q   <= cnt_q + 2'd1;
          if (cnt_q == 2'd3) state_q <= ST_FIN;
        end
        ST_FIN: begin
          il_q    <= il_nx;
          vc_q    <= vc_nx;
          hold_q  <= hold_nx;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign il_out = il_q;
  assign vc_out = vc_q;
  assign done   = done_q;
  assign busy   = (state_q != ST_IDLE);

endmodule

// File: rtl/buck_solver_chk.sv
module buck_solver_chk #(
  parameter int W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                gate_hi,
  input logic                gate_lo,
  input logic signed [W-1:0] il_out,
  input logic signed [W-1:0] vc_out,
  input logic                done,
  input logic                busy
);

  logic [2:0] lat_cnt;
  logic       dead_lat;
  logic       sgn_lat;
  logic       held_lat;
  logic       zero_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt   <= '0;
      dead_lat  <= 1'b0;
      sgn_lat   <= 1'b0;
      held_lat  <= 1'b0;
      zero_hold <= 1'b0;
    end else begin
      if (start && !busy) begin
        lat_cnt  <= 3'd1;
        dead_lat <= !gate_hi && !gate_lo;
        sgn_lat  <= il_out[W-1];
        held_lat <= zero_hold && !gate_hi && !gate_lo;
      end else if (lat_cnt != 3'd0 && lat_cnt != 3'd7) begin
        lat_cnt <= lat_cnt + 3'd1;
      end
      if (done) zero_hold <= dead_lat && (il_out == '0);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (il_out == '0 && vc_out == '0 && !done && !busy)); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == 3'd6)); // R3

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(il_out) && $stable(vc_out))); // R2

  AST_CLAMP_SIGN: assert property (@(posedge clk) disable iff (rst)
    (done && dead_lat) |-> (il_out == '0 || il_out[W-1] == sgn_lat)); // R8

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && held_lat) |-> (il_out == '0)); // R9

endmodule

bind buck_rk4_solver buck_solver_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo),
  .il_out  (il_out),
  .vc_out  (vc_out),
  .done    (done),
  .busy    (busy)
);

// File: tb/tb_buck_rk4_solver.sv
module tb_buck_rk4_solver;

  localparam int W         = 24;
  localparam int FRAC      = 16;
  localparam int CLK_PER   = 10;
  localparam int WATCHDOG  = 100000;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start = 1'b0;
  logic                gate_hi = 1'b0;
  logic                gate_lo = 1'b0;
  logic signed [W-1:0] k_dt_l = '0;
  logic signed [W-1:0] k_dt_c = '0;
  logic signed [W-1:0] k_dt_rc = '0;
  logic signed [W-1:0] k_vsrc = '0;
  logic signed [W-1:0] il_out, vc_out;
  logic                done, busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  longint cur_kl, cur_kc, cur_krc, cur_vs;
  longint ref_il, ref_vc;
  bit     ref_hold;
  int     clamp_events = 0, hold_steps = 0, sat_hits = 0, neg_dead = 0;

  always #(CLK_PER/2) clk = ~clk;

  buck_rk4_solver #(.W(W), .FRAC(FRAC)) dut (
    .clk(clk), .rst(rst), .start(start), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .k_dt_l(k_dt_l), .k_dt_c(k_dt_c), .k_dt_rc(k_dt_rc), .k_vsrc(k_vsrc),
    .il_out(il_out), .vc_out(vc_out), .done(done), .busy(busy)
  );

  function automatic longint sat(longint x);
    longint hi = (longint'(1) <<< (W - 1)) - 1;
    if (x > hi) return hi;
    if (x < -hi - 1) return -hi - 1;
    return x;
  endfunction

  function automatic longint qm(longint a, longint b);
    return (a * b) >>> FRAC;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply_coef();
    k_dt_l  = cur_kl[W-1:0];
    k_dt_c  = cur_kc[W-1:0];
    k_dt_rc = cur_krc[W-1:0];
    k_vsrc  = cur_vs[W-1:0];
  endtask

  // Reference step built from R5..R9.
  task automatic ref_step(bit hi, bit lo);
    bit     dead = !hi && !lo;
    longint u = (hi || (dead && ref_il < 0)) ? cur_vs : 0;
    bit     hold = dead && ref_hold;
    longint ki = 0, kv = 0, ai = 0, av = 0, si, sv, ni, nv;
    bit     clamp;
    longint top = (longint'(1) <<< (W - 1)) - 1;
    if (dead && ref_il < 0) neg_dead++;
    for (int s = 0; s < 4; s++) begin
      if (s == 0) begin si = ref_il; sv = ref_vc; end
      else if (s == 3) begin si = sat(ref_il + ki); sv = sat(ref_vc + kv); end
      else begin si = sat(ref_il + (ki >>> 1)); sv = sat(ref_vc + (kv >>> 1)); end
      ki = hold ? 0 : sat(qm(cur_kl, u - sv));
      kv = sat(qm(cur_kc, hold ? 0 : si) - qm(cur_krc, sv));
      ai += (s == 0 || s == 3) ? ki : 2 * ki;
      av += (s == 0 || s == 3) ? kv : 2 * kv;
    end
    ni = sat(ref_il + qm(ai, ((longint'(1) <<< FRAC) + 3) / 6));
    nv = sat(ref_vc + qm(av, ((longint'(1) <<< FRAC) + 3) / 6));
    clamp = dead && (hold || ni == 0 || ((ni < 0) != (ref_il < 0)));
    if (clamp && !ref_hold) clamp_events++;
    if (hold) hold_steps++;
    ref_il = clamp ? 0 : ni;
    ref_vc = nv;
    ref_hold = clamp;
    if (ref_il == top || ref_vc == top) sat_hits++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(il_out == 0 && vc_out == 0, "R1", "states in reset", il_out, 0);
    chk(!done && !busy, "R1", "done/busy in reset", {done, busy}, 0);
    rst = 1'b0;
    ref_il = 0; ref_vc = 0; ref_hold = 1'b0;
    @(negedge clk);
    chk(il_out == 0 && vc_out == 0 && !busy, "R1", "state after reset", il_out, 0);
  endtask

  task automatic run_step(bit hi, bit lo, bit noise, string tag_in);
    string tag;
    bit dead = !hi && !lo;
    if (tag_in != "") tag = tag_in;
    else if (dead && ref_hold) tag = "R9";
    else if (dead) tag = "R8";
    else if (hi) tag = "R6";
    else tag = "R5";
    @(negedge clk);
    start = 1'b1; gate_hi = hi; gate_lo = lo; apply_coef();
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    for (int k = 0; k < 5; k++) begin
      if (noise) begin
        start   = 1'($urandom % 2);   // R3 pulses while busy
        gate_hi = 1'($urandom % 2);   // R4 late gate changes
        gate_lo = 1'($urandom % 2);
        k_vsrc  = W'($urandom);
        k_dt_l  = W'($urandom);
      end
      @(negedge clk);
      if (k == 3) chk(done == 1'b0, "R2", "done early", done, 0);
    end
    start = 1'b0; gate_hi = hi; gate_lo = lo; apply_coef();
    ref_step(hi, lo);
    chk(done == 1'b1, "R2", "done on fifth edge", done, 1);
    chk(longint'(il_out) == ref_il, tag, "il", il_out, ref_il);
    chk(longint'(vc_out) == ref_vc, tag, "vc", vc_out, ref_vc);
    @(negedge clk);
    chk(!done && !busy, "R3", "no restart after done", {done, busy}, 0);
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'd20240611);
    cur_kl = 65536; cur_kc = 32768; cur_krc = 3277; cur_vs = 2 * 65536;
    apply_coef();
    do_reset();

    // Charge, then deadtime: clamp and hold (R8, R9).
    run_step(1, 0, 0, "R5");
    run_step(1, 0, 0, "R5");
    for (int s = 0; s < 4; s++) run_step(0, 0, 0, "");
    // Low side drives current negative, deadtime with negative current (R6).
    for (int s = 0; s < 3; s++) run_step(0, 1, 0, "R6");
    for (int s = 0; s < 3; s++) run_step(0, 0, 0, "R6");
    run_step(1, 1, 0, "R6");
    // Late input changes have no effect (R4).
    for (int s = 0; s < 4; s++) run_step(s[0], !s[0], 1, "R4");

    // Saturation (R7).
    do_reset();
    cur_kl = 65536; cur_kc = 32768; cur_krc = 0; cur_vs = 100 * 65536;
    for (int s = 0; s < 4; s++) run_step(1, 0, 0, "R7");
    for (int s = 0; s < 2; s++) run_step(0, 1, 0, "R7");

    // Constrained random phases.
    do_reset();
    for (int p = 0; p < 60; p++) begin
      int m = $urandom % 4;
      int n = 1 + $urandom % 3;
      if (p % 20 == 0) begin
        cur_kl  = 6554 + $urandom % 58982;
        cur_kc  = 3277 + $urandom % 29491;
        cur_krc = $urandom % 6554;
        cur_vs  = 65536 * (1 + $urandom % 20);
      end
      for (int s = 0; s < n; s++) run_step(m == 0 || m == 3, m == 1 || m == 3, 1, "");
    end

    chk(clamp_events > 0, "R8", "clamp events seen", clamp_events, 1);
    chk(hold_steps > 0, "R9", "hold steps seen", hold_steps, 1);
    chk(sat_hits > 0, "R7", "saturation seen", sat_hits, 1);
    chk(neg_dead > 0, "R6", "negative deadtime seen", neg_dead, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule